// File: doc/BRIEF.md
# SD Card Response Capture and Readout

This block takes the response a card returns on the command line, delivered as a serial bit stream with a per-bit valid strobe, and assembles it into a stored frame. A frame is either a short 48-bit response or a long 136-bit response. The length is chosen by a select input, which is sampled together with the first valid bit of each frame. Once the last bit has arrived, the frame is copied into a holding register and a response-received flag is raised. A long-response flag then records which kind of frame is held.

The host reads the stored frame through one read-only data word. Each read strobe moves to the next word, starting with the most significant part. A short frame reads as three full 16-bit slices. A long frame starts with a partial word that holds only its top eight bits in the low byte, followed by eight full slices. After the last word the sequence wraps to the first, so the frame can be read again any number of times. The first read clears the received flag. A synchronous soft reset and the asynchronous hardware reset both clear the stored frame, the flags, the read position and any frame that is only partly received.

Top module: `sd_rsp_capture`

## Requirements
- R1: After hardware reset, rd_data_o is 0, rsp_done_o is 0 and rsp_long_o is 0.
- R2: Bits are taken MSB first, only in cycles with rsp_valid_i high. The frame completes on the clock edge that accepts its 48th (short) or 136th (long) valid bit. rsp_done_o is 1 from the next cycle, and not before.
- R3: With a short frame held, successive reads return frame bits 47:32, then 31:16, then 15:0, and then wrap back to 47:32.
- R4: With a long frame held, the first read returns bits 135:128 on rd_data_o[7:0] with rd_data_o[15:8] = 0. The next eight reads return 127:112, 111:96, and so on down to 15:0, and the ninth read wraps to the first word.
- R5: rsp_long_o is 1 when the held frame is a long one and 0 for a short one. It changes only on the edge that completes a frame.
- R6: A cycle with rd_rsp_i high advances the read position and clears rsp_done_o on the following edge.
- R7: When a frame completes in the same cycle as a host read, the completion wins. rsp_done_o stays 1 and the read position returns to the first word of the new frame.
- R8: A cycle with soft_rst_i high clears the stored frame, both flags, the read position and any partly received frame. The next complete frame is then captured exactly as sent.
- R9: rsp_long_sel_i is sampled only with the first valid bit of a frame. Changing it later in the frame has no effect on that frame's length.
- R10: Every newly completed frame presents its first word on rd_data_o, wherever the read position was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous soft reset, one cycle |
| rsp_bit_i | input | 1 | Serial response bit |
| rsp_valid_i | input | 1 | Qualifies rsp_bit_i this cycle |
| rsp_long_sel_i | input | 1 | 1 selects a 136-bit frame, 0 a 48-bit frame; taken with the first bit |
| rd_rsp_i | input | 1 | Host read strobe, one word per cycle high |
| rd_data_o | output | 16 | Current response word |
| rsp_done_o | output | 1 | Response received, cleared by a host read |
| rsp_long_o | output | 1 | Held response is the 136-bit kind |

## Verification
Two functions can land on the same edge: acceptance of a frame's final bit, and a host read strobe. Both try to move the read position and the received flag. The bench first reads a held frame partway, so the position is not at the first word. It then raises the read strobe during the cycle that carries the last bit of a new frame. The check expects the flag to be set and the new frame's first word on the output, not a cleared flag or an advanced position.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;
  localparam int unsigned DEF_WORD_W    = 16;
  localparam int unsigned DEF_SHORT_LEN = 48;
  localparam int unsigned DEF_LONG_LEN  = 136;

  function automatic int unsigned words_for(input int unsigned bits, input int unsigned w);
    return (bits + w - 1) / w;
  endfunction
endpackage

// File: rtl/sd_rsp_shifter.sv
module sd_rsp_shifter #(
  parameter int unsigned SHORT_LEN = 48,
  parameter int unsigned LONG_LEN  = 136,
  localparam int unsigned CNT_W    = $clog2(LONG_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                bit_i,
  input  logic                valid_i,
  input  logic                long_sel_i,
  output logic [LONG_LEN-1:0] frame_o,
  output logic                cap_o,
  output logic                cap_long_o
);
  logic [LONG_LEN-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                long_q;
  logic                long_eff;
  logic                last;

  // length is frozen by the first bit of a frame
  assign long_eff = (cnt_q == '0) ? long_sel_i : long_q;
  assign last     = long_eff ? (cnt_q == CNT_W'(LONG_LEN - 1))
                             : (cnt_q == CNT_W'(SHORT_LEN - 1));
  assign frame_o    = {sh_q[LONG_LEN-2:0], bit_i};
  assign cap_o      = valid_i && last && !soft_rst_i;
  assign cap_long_o = long_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (soft_rst_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (valid_i) begin
      sh_q   <= frame_o;
      long_q <= long_eff;
      cnt_q  <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store #(
  parameter int unsigned SHORT_LEN = 48,
  parameter int unsigned LONG_LEN  = 136
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                ld_i,
  input  logic                ld_long_i,
  input  logic [LONG_LEN-1:0] frame_i,
  output logic [LONG_LEN-1:0] data_o,
  output logic                long_o
);
  logic [LONG_LEN-1:0] trimmed;

  // short frames keep only their own bits; stale upper bits are dropped
  always_comb begin
    trimmed = '0;
    if (ld_long_i) trimmed = frame_i;
    else           trimmed[SHORT_LEN-1:0] = frame_i[SHORT_LEN-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      long_o <= 1'b0;
    end else if (soft_rst_i) begin
      data_o <= '0;
      long_o <= 1'b0;
    end else if (ld_i) begin
      data_o <= trimmed;
      long_o <= ld_long_i;
    end
  end
endmodule

// File: rtl/sd_rsp_reader.sv
module sd_rsp_reader #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SHORT_LEN = 48,
  parameter int unsigned LONG_LEN  = 136,
  localparam int unsigned SW    = sd_rsp_pkg::words_for(SHORT_LEN, WORD_W),
  localparam int unsigned LW    = sd_rsp_pkg::words_for(LONG_LEN, WORD_W),
  localparam int unsigned PTR_W = $clog2(LW),
  localparam int unsigned EXT_L = LW * WORD_W,
  localparam int unsigned EXT_S = SW * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                cap_i,
  input  logic                rd_i,
  input  logic                long_i,
  input  logic [LONG_LEN-1:0] data_i,
  output logic [WORD_W-1:0]   word_o,
  output logic [PTR_W-1:0]    ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] last_idx;
  logic [EXT_L-1:0] ext_l;
  logic [EXT_S-1:0] ext_s;

  assign last_idx = long_i ? PTR_W'(LW - 1) : PTR_W'(SW - 1);
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (soft_rst_i || cap_i) ptr_q <= '0;
    else if (rd_i)               ptr_q <= (ptr_q == last_idx) ? '0 : ptr_q + PTR_W'(1);
  end

  // zero-extend on the left so the top word of a long frame is partial
  always_comb begin
    ext_l = '0;
    ext_l[LONG_LEN-1:0] = data_i;
    ext_s = '0;
    ext_s[SHORT_LEN-1:0] = data_i[SHORT_LEN-1:0];
  end

  always_comb begin
    word_o = '0;
    if (long_i) begin
      for (int k = 0; k < int'(LW); k++)
        if (ptr_q == PTR_W'(k)) word_o = ext_l[(int'(LW) - 1 - k) * int'(WORD_W) +: WORD_W];
    end else begin
      for (int k = 0; k < int'(SW); k++)
        if (ptr_q == PTR_W'(k)) word_o = ext_s[(int'(SW) - 1 - k) * int'(WORD_W) +: WORD_W];
    end
  end
endmodule

// File: rtl/sd_rsp_capture.sv
module sd_rsp_capture #(
  parameter int unsigned WORD_W    = sd_rsp_pkg::DEF_WORD_W,
  parameter int unsigned SHORT_LEN = sd_rsp_pkg::DEF_SHORT_LEN,
  parameter int unsigned LONG_LEN  = sd_rsp_pkg::DEF_LONG_LEN,
  localparam int unsigned LW    = sd_rsp_pkg::words_for(LONG_LEN, WORD_W),
  localparam int unsigned PTR_W = $clog2(LW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              rsp_bit_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_long_sel_i,
  input  logic              rd_rsp_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rsp_done_o
  ,output logic             rsp_long_o
);
  logic [LONG_LEN-1:0] frame_w;
  logic [LONG_LEN-1:0] held_w;
  logic                cap_w;
  logic                cap_long_w;
  logic [PTR_W-1:0]    ptr_w;
  logic                done_q;

  sd_rsp_shifter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .bit_i(rsp_bit_i), .valid_i(rsp_valid_i), .long_sel_i(rsp_long_sel_i),
    .frame_o(frame_w), .cap_o(cap_w), .cap_long_o(cap_long_w)
  );

  sd_rsp_store #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .ld_i(cap_w), .ld_long_i(cap_long_w), .frame_i(frame_w),
    .data_o(held_w), .long_o(rsp_long_o)
  );

  sd_rsp_reader #(.WORD_W(WORD_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_read (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .cap_i(cap_w), .rd_i(rd_rsp_i), .long_i(rsp_long_o), .data_i(held_w),
    .word_o(rd_data_o), .ptr_o(ptr_w)
  );

  // capture outranks a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (soft_rst_i) done_q <= 1'b0;
    else if (cap_w)      done_q <= 1'b1;
    else if (rd_rsp_i)   done_q <= 1'b0;
  end
  assign rsp_done_o = done_q;
endmodule

// File: rtl/sd_rsp_capture_chk.sv
module sd_rsp_capture_chk #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned LONG_LEN = 136,
  parameter int unsigned PTR_W    = 4,
  localparam int unsigned LW   = sd_rsp_pkg::words_for(LONG_LEN, WORD_W),
  localparam int unsigned PART = LONG_LEN - (LW - 1) * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              rd_rsp_i,
  input logic              cap_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              rsp_done_o,
  input logic              rsp_long_o
);
  // R2
  cap_sets_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> rsp_done_o);

  // R6
  read_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rsp_i && !cap_i && !soft_rst_i) |=> !rsp_done_o);

  // R5
  long_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !soft_rst_i) |=> $stable(rsp_long_o));

  // R7
  cap_rewinds_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (ptr_i == '0));

  // R8
  soft_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (rd_data_o == '0 && !rsp_done_o && !rsp_long_o));

  // R4
  long_head_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_long_o && ptr_i == '0) |-> ((rd_data_o >> PART) == '0));
endmodule

bind sd_rsp_capture sd_rsp_capture_chk #(.WORD_W(WORD_W), .LONG_LEN(LONG_LEN), .PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .rd_rsp_i(rd_rsp_i),
  .cap_i(cap_w), .ptr_i(ptr_w), .rd_data_o(rd_data_o),
  .rsp_done_o(rsp_done_o), .rsp_long_o(rsp_long_o)
);

// File: tb/sd_rsp_capture_tb.sv
module sd_rsp_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, rbit = 1'b0, rvalid = 1'b0, lsel = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic done, lng;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_rsp_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .rsp_bit_i(rbit),
    .rsp_valid_i(rvalid), .rsp_long_sel_i(lsel), .rd_rsp_i(rd),
    .rd_data_o(rdata), .rsp_done_o(done), .rsp_long_o(lng)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic l, input logic [135:0] v, input int k);
    if (l) return (k == 0) ? {8'h00, v[135:128]} : v[127 - 16*(k-1) -: 16];
    else   return v[47 - 16*k -: 16];
  endfunction

  function automatic logic [135:0] pattern(input int p);
    logic [135:0] v;
    for (int j = 0; j < 17; j++) v[8*j +: 8] = 8'((p*37 + j*11 + 5) % 256);
    return v;
  endfunction

  // gap: insert idle cycles with a junk bit; flip: toggle length select after first bit
  task automatic send_frame(input logic l, input logic [135:0] v, input bit gap,
                            input bit flip, input bit rd_last, input bit early);
    int n = l ? 136 : 48;
    for (int i = n - 1; i >= 0; i--) begin
      rvalid = 1'b1; rbit = v[i];
      lsel = (flip && i != n - 1) ? ~l : l;
      if (i == 0) begin
        rd = rd_last;
        if (early) check("R2 no early done", {15'd0, done}, 16'd0);
      end
      step;
      rd = 1'b0;
      if (gap && (i % 5 == 0) && i != 0) begin
        rvalid = 1'b0; rbit = ~v[i];
        step;
      end
    end
    rvalid = 1'b0; lsel = 1'b0;
  endtask

  task automatic read_all(input logic l, input logic [135:0] v, input int count);
    int nw = l ? 9 : 3;
    for (int k = 0; k < count; k++) begin
      check(l ? "R4 long word" : "R3 short word", rdata, exp_word(l, v, k % nw));
      rd = 1'b1;
      step;
      rd = 1'b0;
      if (k == 0) check("R6 done cleared", {15'd0, done}, 16'd0);
    end
  endtask

  initial begin
    logic [135:0] v;
    @(negedge clk);
    step; step;
    check("R1 data", rdata, 16'd0);
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 long", {15'd0, lng}, 16'd0);
    rst_n = 1'b1;
    step;

    // sweep short and long frames over patterns, with and without gaps
    for (int p = 0; p < 8; p++) begin
      logic l = p[0];
      v = pattern(p);
      send_frame(l, v, p[1], 1'b0, 1'b0, p > 0);
      check("R2 done set", {15'd0, done}, 16'd1);
      check("R5 long flag", {15'd0, lng}, {15'd0, l});
      read_all(l, v, l ? 19 : 7);
    end

    // R9: length select toggled after first bit is ignored
    v = pattern(20);
    send_frame(1'b0, v, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R9 short kept", {15'd0, lng}, 16'd0);
    read_all(1'b0, v, 3);
    v = pattern(21);
    send_frame(1'b1, v, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R9 long kept", {15'd0, lng}, 16'd1);
    read_all(1'b1, v, 9);

    // R7 / R10: completion coincides with a read, pointer mid-frame
    v = pattern(30);
    send_frame(1'b0, v, 1'b0, 1'b0, 1'b0, 1'b1);
    read_all(1'b0, v, 2);
    v = pattern(31);
    send_frame(1'b1, v, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R7 done wins", {15'd0, done}, 16'd1);
    check("R10 first word", rdata, exp_word(1'b1, v, 0));
    read_all(1'b1, v, 10);

    // R5: partial short frame leaves long flag alone
    for (int i = 0; i < 20; i++) begin
      rvalid = 1'b1; rbit = i[0]; lsel = 1'b0;
      step;
    end
    rvalid = 1'b0;
    check("R5 flag held", {15'd0, lng}, 16'd1);
    check("R5 data held", rdata, exp_word(1'b1, v, 1));

    // R8: soft reset mid-frame, then a clean frame
    soft_rst = 1'b1;
    step;
    soft_rst = 1'b0;
    check("R8 data", rdata, 16'd0);
    check("R8 done", {15'd0, done}, 16'd0);
    check("R8 long", {15'd0, lng}, 16'd0);
    v = pattern(40);
    send_frame(1'b0, v, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 recapture", {15'd0, done}, 16'd1);
    read_all(1'b0, v, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule